// File: doc/BRIEF.md
# One-time-programmable page programming controller

This block sits between a single-cycle CPU bus and a small one-time-programmable byte array, which is modelled here as a bank of registers. Software arms the block by setting a latch-enable bit in the control register. From then on, CPU writes into the array's address range are not stored in the array. They are captured into a sixteen-slot page latch, and each slot has its own valid flag. All latched bytes must share the same page: every address bit above the low four must match. The first accepted write fixes the page. A write to any other page is dropped and raises a sticky page-error flag.

Setting the program-enable bit while latch-enable is already set starts a commit pulse. The pulse lasts a parameterised number of clock cycles and drives a busy flag for its whole length. When the pulse ends, every valid slot is ORed into its array byte, so programming can only turn bits from 0 to 1. While latch-enable is set, array reads return 0x00 rather than the stored data.

Clearing latch-enable, or asserting the stop-mode input, returns the block to plain read mode. Either event also abandons any commit in progress and discards the latched bytes.

Top module: `otp_page_prog`

## Requirements
- R1: After reset the control register reads 0x00, every array byte reads 0x00 (the erased value) and `prog_busy` is low.
- R2: The control register is selected when `addr` has its top bit set and all other bits zero. Its bits are: bit 7 reads 0, bit 6 is latch-enable, bit 5 is program-enable, bit 4 is busy, bit 3 is page-error, and bits 2..0 read 0. Bit 5 and bit 4 are both high exactly while a commit pulse runs. Any other address with the top bit set reads 0x00.
- R3: A control write with bit 5 set, made while latch-enable is clear, starts no commit: `prog_busy` stays low and program-enable reads 0. Writing 0xFF from read mode therefore reads back 0x40.
- R4: While latch-enable is set, a read of any array address returns 0x00.
- R5: An array write made while latch-enable is clear leaves the array unchanged.
- R6: At the end of a commit, each array byte in the latched page becomes its old value ORed with its slot's data if that slot is valid, and keeps its old value otherwise. Bytes outside the page are unchanged.
- R7: The first array write of a session fixes the page (the address bits above bit 3). A later write to a different page is ignored and sets page-error. Page-error stays set until latch-enable is cleared.
- R8: A commit holds `prog_busy` high for exactly PULSE_CYCLES clock cycles, with the array updated when it falls. Latch-enable stays set afterwards, and all slots are emptied, so the next write may choose a new page.
- R9: A control write with bit 6 clear ends the session. It clears program-enable and page-error, aborts a running commit without changing the array, and discards all latched bytes.
- R10: Asserting `stop_req` has the same effect as clearing latch-enable: both latch-enable and program-enable read 0 and any running commit is aborted with the array unchanged.
- R11: While a commit runs, array writes are ignored, and so are control writes that keep bit 6 set.
- R12: A second write to the same slot within a session replaces the latched byte rather than merging with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W+1 | Bus address; top bit clear selects the array |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; `rdata` updates at the same edge |
| stop_req | input | 1 | Stop-mode request, active high |
| rdata | output | 8 | Registered read data |
| prog_busy | output | 1 | High while a commit pulse runs |

## Verification
Each round programs every page of a small array. A different arithmetic pattern of which slots are written, and with which values, is used for each page and each round. Every byte is then read back and compared with a bench model, which ORs the new data into the old. Repeating the rounds over the same bytes separates a true OR merge from an overwrite. Skipped slots separate valid-gated commit from a commit of all sixteen slots. Directed sequences separate the remaining cases: a commit that finishes from one that is aborted (by a control write, or by stop mode), a write into the fixed page from a write into a foreign page, and a second write to the same slot from a first write.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int CB_LATCH = 6;
  localparam int CB_PEN   = 5;
  localparam int CB_BUSY  = 4;
  localparam int CB_GERR  = 3;
  localparam int SLOTS    = 16;
  localparam int SLOT_W   = 4;

  // cumulative programming: bits may only be set
  function automatic logic [7:0] or_merge(input logic [7:0] old_v,
                                          input logic [7:0] add_v,
                                          input logic       en);
    return en ? (old_v | add_v) : old_v;
  endfunction

  function automatic logic [7:0] ctrl_image(input logic latch,
                                            input logic busy,
                                            input logic gerr);
    logic [7:0] v;
    v = 8'h00;
    v[CB_LATCH] = latch;
    v[CB_PEN]   = busy;
    v[CB_BUSY]  = busy;
    v[CB_GERR]  = gerr;
    return v;
  endfunction
endpackage

// File: rtl/otp_ctrl_reg.sv
module otp_ctrl_reg
  import otp_pkg::*;
#(
  parameter int PULSE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] wdata,
  input  logic       stop_req,
  output logic       latch_q,
  output logic       busy,
  output logic       commit_start,
  output logic       commit_done,
  output logic       session_end
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign session_end  = latch_q && (stop_req || (ctrl_wr && !wdata[CB_LATCH]));
  assign commit_start = ctrl_wr && !stop_req && latch_q && !busy &&
                        wdata[CB_LATCH] && wdata[CB_PEN];
  assign commit_done  = busy && (cnt_q == '0) && !session_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      busy    <= 1'b0;
      cnt_q   <= '0;
    end else if (stop_req || session_end) begin
      latch_q <= 1'b0;
      busy    <= 1'b0;
      cnt_q   <= '0;
    end else if (busy) begin
      if (commit_done) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (ctrl_wr) begin
      latch_q <= wdata[CB_LATCH];
      if (commit_start) begin
        busy  <= 1'b1;
        cnt_q <= CNT_LOAD;
      end
    end
  end
endmodule

// File: rtl/otp_page_latch.sv
module otp_page_latch
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_req,
  input  logic [ADDR_W-1:0]        cap_addr,
  input  logic [7:0]               cap_data,
  input  logic                     clear_slots,
  input  logic                     clear_err,
  output logic [SLOTS-1:0][7:0]    slot_data,
  output logic [SLOTS-1:0]         slot_valid,
  output logic [ADDR_W-SLOT_W-1:0] group_q,
  output logic                     gerr_q,
  output logic                     latch_capture,
  output logic                     group_reject
);
  localparam int GW = ADDR_W - SLOT_W;

  logic          page_open;
  logic [GW-1:0] req_group;
  logic [SLOT_W-1:0] req_slot;

  assign req_group     = cap_addr[ADDR_W-1:SLOT_W];
  assign req_slot      = cap_addr[SLOT_W-1:0];
  assign page_open     = (slot_valid == '0) || (req_group == group_q);
  assign latch_capture = cap_req && page_open;
  assign group_reject  = cap_req && !page_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      group_q <= '0;
      gerr_q  <= 1'b0;
    end else begin
      if (latch_capture) group_q <= req_group;
      if (clear_err)         gerr_q <= 1'b0;
      else if (group_reject) gerr_q <= 1'b1;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_data[s]  <= 8'h00;
        slot_valid[s] <= 1'b0;
      end else if (clear_slots) begin
        slot_valid[s] <= 1'b0;
      end else if (latch_capture && (req_slot == SLOT_W'(s))) begin
        slot_data[s]  <= cap_data;
        slot_valid[s] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit_done,
  input  logic [ADDR_W-SLOT_W-1:0] group,
  input  logic [SLOTS-1:0][7:0]    slot_data,
  input  logic [SLOTS-1:0]         slot_valid,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_cell
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int GW    = ADDR_W - SLOT_W;

  logic [7:0] mem [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_cell
    localparam logic [GW-1:0] CELL_GRP = GW'(a >> SLOT_W);
    localparam int            CELL_SLOT = a % SLOTS;
    logic hit;
    assign hit = commit_done && (group == CELL_GRP);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[a] <= 8'h00;
      else if (hit) mem[a] <= or_merge(mem[a], slot_data[CELL_SLOT],
                                       slot_valid[CELL_SLOT]);
    end
  end

  assign rd_cell = mem[rd_addr];
endmodule

// File: rtl/otp_page_prog.sv
module otp_page_prog
  import otp_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int PULSE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W:0]   addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              stop_req,
  output logic [7:0]        rdata,
  output logic              prog_busy
);
  localparam int GW = ADDR_W - SLOT_W;

  logic addr_is_array, ctrl_sel, ctrl_wr, cap_req;
  logic latch_q, busy, commit_start, commit_done, session_end;
  logic [SLOTS-1:0][7:0] slot_data;
  logic [SLOTS-1:0]      slot_valid;
  logic [GW-1:0]         group_q;
  logic gerr_q, latch_capture, group_reject;
  logic [7:0] rd_cell, rd_next;

  assign addr_is_array = !addr[ADDR_W];
  assign ctrl_sel      = addr[ADDR_W] && (addr[ADDR_W-1:0] == '0);
  assign ctrl_wr       = wr_en && ctrl_sel;
  assign cap_req       = wr_en && addr_is_array && latch_q && !busy && !stop_req;

  otp_ctrl_reg #(.PULSE_CYCLES(PULSE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(wdata),
    .stop_req(stop_req), .latch_q(latch_q), .busy(busy),
    .commit_start(commit_start), .commit_done(commit_done),
    .session_end(session_end)
  );

  otp_page_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req),
    .cap_addr(addr[ADDR_W-1:0]), .cap_data(wdata),
    .clear_slots(session_end || commit_done), .clear_err(session_end),
    .slot_data(slot_data), .slot_valid(slot_valid), .group_q(group_q),
    .gerr_q(gerr_q), .latch_capture(latch_capture),
    .group_reject(group_reject)
  );

  otp_cell_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .commit_done(commit_done), .group(group_q),
    .slot_data(slot_data), .slot_valid(slot_valid),
    .rd_addr(addr[ADDR_W-1:0]), .rd_cell(rd_cell)
  );

  always_comb begin
    if (addr_is_array) rd_next = latch_q ? 8'h00 : rd_cell;
    else if (ctrl_sel) rd_next = ctrl_image(latch_q, busy, gerr_q);
    else               rd_next = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= rd_next;
  end

  assign prog_busy = busy;
endmodule

// File: rtl/otp_page_prog_checker.sv
module otp_page_prog_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              addr_is_array,
  input logic              ctrl_wr,
  input logic [7:0]        wdata,
  input logic              stop_req,
  input logic              latch_q,
  input logic              busy,
  input logic              commit_done,
  input logic              session_end,
  input logic              group_reject,
  input logic              gerr_q,
  input logic [15:0]       slot_valid,
  input logic [7:0]        rdata
);
  assert_pen_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[5] && !latch_q) |=> !busy);

  assert_masked_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr_is_array && latch_q) |=> (rdata == 8'h00));

  assert_reject_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    group_reject |=> gerr_q);

  assert_done_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> (!busy && (slot_valid == 16'h0)));

  assert_busy_in_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> latch_q);

  assert_session_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    session_end |=> (!busy && !gerr_q && (slot_valid == 16'h0)));

  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!latch_q && !busy));

  assert_frozen_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit_done && !session_end) |=> $stable(slot_valid));
endmodule

bind otp_page_prog otp_page_prog_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr_is_array(addr_is_array),
  .ctrl_wr(ctrl_wr), .wdata(wdata), .stop_req(stop_req), .latch_q(latch_q),
  .busy(busy), .commit_done(commit_done), .session_end(session_end),
  .group_reject(group_reject), .gerr_q(gerr_q), .slot_valid(slot_valid),
  .rdata(rdata)
);

// File: tb/otp_page_prog_test.sv
module otp_page_prog_test;
  localparam int AW = 6;
  localparam int PC = 5;
  localparam logic [AW:0] CTRL = 7'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW:0] addr = '0;
  logic [7:0] wdata = 8'h00;
  logic wr_en = 1'b0, rd_en = 1'b0, stop_req = 1'b0;
  logic [7:0] rdata;
  logic prog_busy;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [64];
  logic [7:0] pend [16];
  logic       pv [16];

  always #10 clk = ~clk;

  otp_page_prog #(.ADDR_W(AW), .PULSE_CYCLES(PC)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .stop_req(stop_req), .rdata(rdata), .prog_busy(prog_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    for (int a = 0; a < 64; a++) begin
      rd(7'(a), v);
      chk(tag, v, model[a]);
    end
  endtask

  function automatic int pat(int r, int g, int s);
    return (s * 37 + g * 11 + r * 73 + 1) & 8'hFF;
  endfunction

  function automatic bit incl(int r, int g, int s);
    return ((s * 7 + g * 3 + r * 5) % 3) != 0;
  endfunction

  task automatic wait_busy(output int n);
    n = 0;
    while (prog_busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    for (int a = 0; a < 64; a++) model[a] = 8'h00;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy", prog_busy, 0);
    rd(CTRL, v); chk("R1 ctrl", v, 8'h00);
    check_all("R1 erased");

    // R2: unused upper address reads zero
    rd(7'h45, v); chk("R2 unused", v, 8'h00);

    // R5: array write in read mode ignored
    wr(7'h05, 8'hAA);
    rd(7'h05, v); chk("R5 ignored", v, 8'h00);

    // R3: program-enable without latch-enable
    wr(CTRL, 8'h20);
    chk("R3 busy", prog_busy, 0);
    rd(CTRL, v); chk("R3 ctrl", v, 8'h00);
    wr(CTRL, 8'hFF);
    chk("R3 busy2", prog_busy, 0);
    rd(CTRL, v); chk("R2 R3 ctrl 0x40", v, 8'h40);
    wr(CTRL, 8'h00);

    // R6 R7 R12 R8 R4: page sweeps
    for (int r = 0; r < 3; r++) begin
      for (int g = 0; g < 4; g++) begin
        for (int s = 0; s < 16; s++) pv[s] = 1'b0;
        wr(CTRL, 8'h40);
        for (int s = 0; s < 16; s++) begin
          if (incl(r, g, s)) begin
            if (s == 3) wr(7'((g << 4) | s), ~8'(pat(r, g, s)));  // R12
            wr(7'((g << 4) | s), 8'(pat(r, g, s)));
            pend[s] = 8'(pat(r, g, s)); pv[s] = 1'b1;
          end
        end
        wr(7'((((g + 1) % 4) << 4) | 2), 8'h81);
        rd(CTRL, v); chk("R7 page error", v, 8'h48);
        rd(7'((g << 4) | 1), v); chk("R4 masked read", v, 8'h00);
        wr(CTRL, 8'h60);
        rd(CTRL, v); chk("R2 ctrl busy", v, 8'h78);
        wait_busy(n);
        chk("R8 pulse length", n + 1, PC);
        rd(CTRL, v); chk("R8 ctrl after", v, 8'h48);
        wr(CTRL, 8'h00);
        rd(CTRL, v); chk("R9 ctrl cleared", v, 8'h00);
        for (int s = 0; s < 16; s++)
          if (pv[s]) model[(g << 4) | s] = model[(g << 4) | s] | pend[s];
        check_all("R6 R12 merge");
      end
    end

    // R9: abort by clearing latch-enable
    wr(CTRL, 8'h40);
    wr(7'h10, 8'hFF);
    wr(CTRL, 8'h60);
    @(negedge clk);
    wr(CTRL, 8'h00);
    chk("R9 abort busy", prog_busy, 0);
    rd(7'h10, v); chk("R9 no update", v, model[16]);
    wr(CTRL, 8'h40);
    wr(CTRL, 8'h60);
    wait_busy(n);
    wr(CTRL, 8'h00);
    rd(7'h10, v); chk("R9 discarded", v, model[16]);

    // R10: stop mode aborts
    wr(CTRL, 8'h40);
    wr(7'h21, 8'hFF);
    wr(CTRL, 8'h60);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk("R10 busy", prog_busy, 0);
    rd(CTRL, v); chk("R10 ctrl", v, 8'h00);
    rd(7'h21, v); chk("R10 no update", v, model[33]);

    // R11 and R8 slot release
    wr(CTRL, 8'h40);
    wr(7'h02, 8'h80);
    wr(CTRL, 8'h60);
    wr(7'h07, 8'hFF);
    wr(CTRL, 8'h40);
    chk("R11 still busy", prog_busy, 1);
    wait_busy(n);
    wr(7'h33, 8'h40);
    rd(CTRL, v); chk("R8 new page allowed", v, 8'h40);
    wr(CTRL, 8'h60);
    wait_busy(n);
    wr(CTRL, 8'h00);
    model[2]  = model[2] | 8'h80;
    model[51] = model[51] | 8'h40;
    rd(7'h02, v); chk("R11 committed", v, model[2]);
    rd(7'h07, v); chk("R11 ignored write", v, model[7]);
    rd(7'h33, v); chk("R8 second page", v, model[51]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule